// File: doc/BRIEF.md
# ECC Memory Scrubber

This block walks a frame-organised memory, one word after another and frame after frame, without ever stopping. Every stored word is a SECDED codeword. Each word is read back and decoded. When a word holds a single flipped bit, the repaired codeword is written back to the same address. A word that cannot be repaired is left as it is. It is counted, and the frame that holds it is latched in a status register. Software polls that register and rewrites the damaged frame itself.

The block reaches the memory through a single synchronous port with a read latency of one cycle. A small register port gives software two saturating error counters, a sticky uncorrectable-error flag, the latched frame number and a clear control. An injection port XORs a chosen bit mask into a stored codeword. This lets a test plant single, double or wider faults. Each injection is a read followed by a write, and it is slotted in between two scrub words.

Top module: `ecc_scrubber`

## Requirements
- R1: A codeword has DATA_W+P+1 bits, where P is the smallest count with 2^P >= DATA_W+P+1 (7 bits of overhead for 32 data bits, 39 bits in all). Bit 0 holds even parity over the whole codeword. Bits 1..DATA_W+P are Hamming positions, with check bits at the power-of-two positions and data filling the other positions from the LSB up. The all-zero codeword is valid.
- R2: With no faults present, the scan reads word addresses 0, 1, ... DEPTH-1 (address = frame*WPF + word) at a rate of one word per 3 cycles, then wraps to 0. `scan_done` is high for exactly one cycle at each wrap, so on a clean memory successive pulses are 3*DEPTH cycles apart.
- R3: A word whose syndrome XOR of set positions lies within 0..DATA_W+P and whose overall parity is odd is a single error. The bit named by the syndrome is flipped (syndrome 0 means bit 0), and the result is written to the same address in the cycle right after the check. A word that is not a single error is never written by the scan.
- R4: The scan position does not advance before the corrective write is done, so the next scan read after a repair goes to the following address.
- R5: Even parity with a nonzero syndrome, or odd parity with a syndrome beyond DATA_W+P, is uncorrectable. Such a word is not written, and only the uncorrectable counter is raised.
- R6: Register 2 reads the single-error count and register 3 the uncorrectable count. Each counter is CNT_W bits wide and stops at 2^CNT_W-1.
- R7: The first uncorrectable error sets bit 0 of register 1 and latches its frame number into register 4. Later uncorrectable errors raise the counter but leave the latched frame unchanged until a clear.
- R8: A write to register 0 with bit 0 set zeroes both counters, the flag and the latched frame, and the clear takes precedence over an event in the same cycle. A write to register 0 with bit 0 clear, or a write to any other register, has no effect.
- R9: While `inj_busy` is low, a pulse on `inj_req` captures `inj_addr` and `inj_mask`. The stored word is then replaced by itself XOR the mask, through a read and a write placed between scrub words. While `inj_busy` is high, requests are ignored.
- R10: `reg_rdata` carries the selected register in the cycle after `reg_rd`. It is zero in any cycle that follows no read, and unassigned addresses read as zero.
- R11: After reset, all registers read zero and no memory access is made while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Word address |
| mem_wdata | output | CW_W | Codeword to store |
| mem_rdata | input | CW_W | Codeword read, valid one cycle after a read |
| inj_req | input | 1 | Injection request pulse |
| inj_addr | input | AW | Word address to corrupt |
| inj_mask | input | CW_W | Bits to flip |
| inj_busy | output | 1 | Injection pending or in progress |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | REG_DW | Register write data |
| reg_rdata | output | REG_DW | Register read data |
| scan_done | output | 1 | One-cycle pulse on every wrap of the scan |

## Verification
The hardest states to reach are the ones where the uncorrectable path has to coexist with the register file. These include a second uncorrectable error that must not overwrite the latched frame, and a word that keeps being found bad on every pass until it is rewritten. The bench uses the injection port to plant two-bit and three-bit masks, polls the counter until the scan has met the fault once, and then injects the same mask again to restore the word before the next pass. A scoreboard holds every memory write the bench expects, both injections and repairs. Any write it does not expect, such as a stray write-back of an uncorrectable word or a second injection accepted while busy, shows up at once.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;

  typedef enum logic [2:0] {
    ST_ISSUE,
    ST_WAIT,
    ST_CHK,
    ST_WB,
    ST_IWAIT,
    ST_ICHK,
    ST_IWB
  } scrub_state_e;

  localparam logic [2:0] RA_CTRL   = 3'd0;
  localparam logic [2:0] RA_FLAGS  = 3'd1;
  localparam logic [2:0] RA_SCNT   = 3'd2;
  localparam logic [2:0] RA_DCNT   = 3'd3;
  localparam logic [2:0] RA_DFRAME = 3'd4;

  // number of Hamming check bits for a data width
  function automatic int check_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

endpackage

// File: rtl/ecc_secded_check.sv
module ecc_secded_check
  import ecc_scrub_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int P     = check_bits(DATA_W),
  localparam int N     = DATA_W + P,
  localparam int CW_W  = N + 1
) (
  input  logic [CW_W-1:0] cw_i,
  output logic            sgl_o,
  output logic            dbl_o,
  output logic [CW_W-1:0] fixed_o
);

  logic [P-1:0] syn;
  logic         par;
  logic         in_range;

  always_comb begin
    syn = '0;
    for (int i = 1; i <= N; i++) begin
      if (cw_i[i]) syn = syn ^ P'(i);
    end
    par = ^cw_i;
  end

  assign in_range = (32'(syn) <= 32'(N));
  assign sgl_o    = par & in_range;
  assign dbl_o    = (!par && (syn != '0)) || (par && !in_range);

  always_comb begin
    for (int i = 0; i < CW_W; i++) begin
      fixed_o[i] = cw_i[i] ^ (sgl_o && (32'(syn) == 32'(i)));
    end
  end

endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
  import ecc_scrub_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int WPF    = 8,
  parameter int CW_W   = 39,
  localparam int DEPTH = FRAMES * WPF,
  localparam int AW    = $clog2(DEPTH),
  localparam int FW    = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int WW    = (WPF > 1) ? $clog2(WPF) : 1
) (
  input  logic            clk,
  input  logic            rst,
  output logic            mem_en_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [CW_W-1:0] mem_wdata_o,
  input  logic [CW_W-1:0] mem_rdata_i,
  input  logic            inj_req_i,
  input  logic [AW-1:0]   inj_addr_i,
  input  logic [CW_W-1:0] inj_mask_i,
  output logic            inj_busy_o,
  input  logic            dec_sgl_i,
  input  logic            dec_dbl_i,
  input  logic [CW_W-1:0] dec_fixed_i,
  output logic            sgl_evt_o,
  output logic            dbl_evt_o,
  output logic [FW-1:0]   evt_frame_o,
  output logic            scan_done_o
);

  scrub_state_e    state_q;
  logic [FW-1:0]   frame_q;
  logic [WW-1:0]   word_q;
  logic            pend_q;
  logic [AW-1:0]   inj_addr_q;
  logic [CW_W-1:0] inj_mask_q;
  logic [AW-1:0]   cur_addr;
  logic            last_word;
  logic            last_frame;

  assign cur_addr   = AW'(int'(frame_q) * WPF + int'(word_q));
  assign last_word  = (int'(word_q) == WPF - 1);
  assign last_frame = (int'(frame_q) == FRAMES - 1);
  assign inj_busy_o = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_ISSUE;
      frame_q     <= '0;
      word_q      <= '0;
      pend_q      <= 1'b0;
      inj_addr_q  <= '0;
      inj_mask_q  <= '0;
      mem_en_o    <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      sgl_evt_o   <= 1'b0;
      dbl_evt_o   <= 1'b0;
      evt_frame_o <= '0;
      scan_done_o <= 1'b0;
    end else begin
      mem_en_o    <= 1'b0;
      mem_we_o    <= 1'b0;
      sgl_evt_o   <= 1'b0;
      dbl_evt_o   <= 1'b0;
      scan_done_o <= 1'b0;
      if (inj_req_i && !pend_q) begin
        pend_q     <= 1'b1;
        inj_addr_q <= inj_addr_i;
        inj_mask_q <= inj_mask_i;
      end
      case (state_q)
        ST_ISSUE: begin
          mem_en_o <= 1'b1;
          if (pend_q) begin
            mem_addr_o <= inj_addr_q;
            state_q    <= ST_IWAIT;
          end else begin
            mem_addr_o <= cur_addr;
            state_q    <= ST_WAIT;
          end
        end
        ST_WAIT:  state_q <= ST_CHK;
        ST_IWAIT: state_q <= ST_ICHK;
        ST_CHK: begin
          if (dec_sgl_i) begin
            mem_en_o    <= 1'b1;
            mem_we_o    <= 1'b1;
            mem_wdata_o <= dec_fixed_i;
            sgl_evt_o   <= 1'b1;
            evt_frame_o <= frame_q;
            state_q     <= ST_WB;
          end else begin
            if (dec_dbl_i) begin
              dbl_evt_o   <= 1'b1;
              evt_frame_o <= frame_q;
            end
            if (last_word) begin
              word_q <= '0;
              if (last_frame) begin
                frame_q     <= '0;
                scan_done_o <= 1'b1;
              end else begin
                frame_q <= frame_q + FW'(1);
              end
            end else begin
              word_q <= word_q + WW'(1);
            end
            state_q <= ST_ISSUE;
          end
        end
        ST_WB: begin
          if (last_word) begin
            word_q <= '0;
            if (last_frame) begin
              frame_q     <= '0;
              scan_done_o <= 1'b1;
            end else begin
              frame_q <= frame_q + FW'(1);
            end
          end else begin
            word_q <= word_q + WW'(1);
          end
          state_q <= ST_ISSUE;
        end
        ST_ICHK: begin
          mem_en_o    <= 1'b1;
          mem_we_o    <= 1'b1;
          mem_wdata_o <= mem_rdata_i ^ inj_mask_q;
          state_q     <= ST_IWB;
        end
        ST_IWB: begin
          pend_q  <= 1'b0;
          state_q <= ST_ISSUE;
        end
        default: state_q <= ST_ISSUE;
      endcase
    end
  end

  // R4
  wb_hold_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WB) |-> ($stable(word_q) && $stable(frame_q)));

  // R3
  wb_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CHK && dec_sgl_i) |=> (mem_we_o && mem_addr_o == $past(mem_addr_o)));

  // R2
  scan_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    scan_done_o |=> !scan_done_o);

endmodule

// File: rtl/scrub_regs.sv
module scrub_regs
  import ecc_scrub_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FW     = 4,
  parameter int REG_DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sgl_evt_i,
  input  logic              dbl_evt_i,
  input  logic [FW-1:0]     evt_frame_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o
);

  logic [CNT_W-1:0] sgl_q;
  logic [CNT_W-1:0] dbl_q;
  logic             flag_q;
  logic [FW-1:0]    frame_q;
  logic             clr;
  logic             wdata_unused;

  assign clr          = reg_wr_i && (reg_addr_i == RA_CTRL) && reg_wdata_i[0];
  assign wdata_unused = ^reg_wdata_i[REG_DW-1:1];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sgl_q   <= '0;
      dbl_q   <= '0;
      flag_q  <= 1'b0;
      frame_q <= '0;
    end else begin
      if (sgl_evt_i && (sgl_q != '1)) sgl_q <= sgl_q + CNT_W'(1);
      if (dbl_evt_i && (dbl_q != '1)) dbl_q <= dbl_q + CNT_W'(1);
      if (dbl_evt_i && !flag_q) begin
        flag_q  <= 1'b1;
        frame_q <= evt_frame_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !reg_rd_i) begin
      reg_rdata_o <= '0;
    end else begin
      case (reg_addr_i)
        RA_FLAGS:  reg_rdata_o <= REG_DW'(flag_q);
        RA_SCNT:   reg_rdata_o <= REG_DW'(sgl_q);
        RA_DCNT:   reg_rdata_o <= REG_DW'(dbl_q);
        RA_DFRAME: reg_rdata_o <= REG_DW'(frame_q);
        default:   reg_rdata_o <= '0;
      endcase
    end
  end

  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sgl_q == '1 && !clr) |=> (sgl_q == '1));

  // R7
  frame_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> (flag_q && $stable(frame_q)));

endmodule

// File: rtl/ecc_scrubber.sv
module ecc_scrubber
  import ecc_scrub_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int WPF    = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_DW = 32,
  localparam int CW_W  = DATA_W + check_bits(DATA_W) + 1,
  localparam int AW    = $clog2(FRAMES * WPF),
  localparam int FW    = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [CW_W-1:0]   mem_wdata,
  input  logic [CW_W-1:0]   mem_rdata,
  input  logic              inj_req,
  input  logic [AW-1:0]     inj_addr,
  input  logic [CW_W-1:0]   inj_mask,
  output logic              inj_busy,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              scan_done
);

  logic            dec_sgl;
  logic            dec_dbl;
  logic [CW_W-1:0] dec_fixed;
  logic            sgl_evt;
  logic            dbl_evt;
  logic [FW-1:0]   evt_frame;

  ecc_secded_check #(.DATA_W(DATA_W)) u_check (
    .cw_i    (mem_rdata),
    .sgl_o   (dec_sgl),
    .dbl_o   (dec_dbl),
    .fixed_o (dec_fixed)
  );

  scrub_seq #(.FRAMES(FRAMES), .WPF(WPF), .CW_W(CW_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .mem_en_o    (mem_en),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .inj_req_i   (inj_req),
    .inj_addr_i  (inj_addr),
    .inj_mask_i  (inj_mask),
    .inj_busy_o  (inj_busy),
    .dec_sgl_i   (dec_sgl),
    .dec_dbl_i   (dec_dbl),
    .dec_fixed_i (dec_fixed),
    .sgl_evt_o   (sgl_evt),
    .dbl_evt_o   (dbl_evt),
    .evt_frame_o (evt_frame),
    .scan_done_o (scan_done)
  );

  scrub_regs #(.CNT_W(CNT_W), .FW(FW), .REG_DW(REG_DW)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .sgl_evt_i   (sgl_evt),
    .dbl_evt_i   (dbl_evt),
    .evt_frame_i (evt_frame),
    .reg_wr_i    (reg_wr),
    .reg_rd_i    (reg_rd),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata)
  );

  // R5
  no_dbl_write_chk: assert property (@(posedge clk) disable iff (rst)
    dbl_evt |-> !mem_we);

  // R3
  we_has_en_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);

endmodule

// File: tb/test_ecc_scrubber.sv
module test_ecc_scrubber;

  localparam int FR    = 4;
  localparam int WPF   = 4;
  localparam int DEPTH = FR * WPF;
  localparam int AW    = 4;
  localparam int CW    = 39;
  localparam int CNTW  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mem_en, mem_we, inj_busy, scan_done;
  logic [AW-1:0] mem_addr;
  logic [CW-1:0] mem_wdata, mem_rdata;
  logic          inj_req = 1'b0;
  logic [AW-1:0] inj_addr = '0;
  logic [CW-1:0] inj_mask = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0, reg_rdata;

  always #5 clk = ~clk;

  ecc_scrubber #(.FRAMES(FR), .WPF(WPF), .DATA_W(32), .CNT_W(CNTW), .REG_DW(32)) i_ecc_scrubber (
    .clk(clk), .rst(rst), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .inj_req(inj_req), .inj_addr(inj_addr),
    .inj_mask(inj_mask), .inj_busy(inj_busy), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scan_done(scan_done)
  );

  // memory model, one cycle read latency
  logic [CW-1:0] mem_q [DEPTH];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      mem_rdata <= '0;
    end else if (mem_en) begin
      if (mem_we) mem_q[mem_addr] <= mem_wdata;
      else mem_rdata <= mem_q[mem_addr];
    end
  end

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check_eq(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct { int addr; logic [CW-1:0] data; bit fix; } wr_item_t;
  wr_item_t exp_q[$];
  logic [CW-1:0] shadow [DEPTH];
  int  scan_t[$];
  bit  nxt_pend = 0;
  int  nxt_addr = 0;

  // monitor: every memory write must match the scoreboard head
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_en && mem_we) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R3/R5 unexpected write actual=%0d:%0h expected=none", mem_addr, mem_wdata);
        end else begin
          wr_item_t it;
          it = exp_q.pop_front();
          check_eq(it.fix ? "R3 addr" : "R9 addr", 64'(mem_addr), 64'(it.addr));
          check_eq(it.fix ? "R3 data" : "R9 data", 64'(mem_wdata), 64'(it.data));
          if (it.fix) begin nxt_pend = 1; nxt_addr = (it.addr + 1) % DEPTH; end
        end
      end else if (mem_en && nxt_pend) begin
        check_eq("R4 next read", 64'(mem_addr), 64'(nxt_addr));
        nxt_pend = 0;
      end
      if (scan_done) scan_t.push_back(cyc);
    end
  end

  task automatic reg_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic inject(int a, logic [CW-1:0] m, bit fix);
    @(negedge clk);
    while (inj_busy) @(negedge clk);
    inj_req = 1; inj_addr = AW'(a); inj_mask = m;
    exp_q.push_back('{a, shadow[a] ^ m, 1'b0});
    if (fix) exp_q.push_back('{a, shadow[a], 1'b1});
    else shadow[a] = shadow[a] ^ m;
    @(negedge clk); inj_req = 0;
  endtask

  task automatic drain(string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 600) begin @(negedge clk); n++; end
    check_eq(req, 64'(exp_q.size()), 64'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic poll_dcnt(int target);
    logic [31:0] d;
    int n = 0;
    d = 0;
    while (int'(d) < target && n < 200) begin reg_read(3'd3, d); n++; end
  endtask

  // plant an uncorrectable fault, wait for its detection, then restore the word
  task automatic dbl_round(int a, logic [CW-1:0] m, int target);
    inject(a, m, 0);
    drain("R9 inject");
    poll_dcnt(target);
    inject(a, m, 0);
    drain("R9 repair");
  endtask

  logic [31:0] d;

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
    @(negedge clk);
    // R11: no access during reset
    check_eq("R11 mem_en in reset", 64'(mem_en), 64'd0);
    repeat (3) @(negedge clk);
    rst = 0;
    reg_read(3'd1, d); check_eq("R11 flag", 64'(d), 0);
    reg_read(3'd2, d); check_eq("R11 scnt", 64'(d), 0);
    reg_read(3'd3, d); check_eq("R11 dcnt", 64'(d), 0);
    reg_read(3'd4, d); check_eq("R11 frame", 64'(d), 0);
    reg_read(3'd6, d); check_eq("R10 unused addr", 64'(d), 0);
    @(negedge clk); check_eq("R10 idle rdata", 64'(reg_rdata), 0);

    // R2: scan period on clean memory
    while (scan_t.size() < 2) @(negedge clk);
    check_eq("R2 scan period", 64'(scan_t[1] - scan_t[0]), 64'(3 * DEPTH));

    // R1/R3: single faults on a data bit, overall parity, a check bit, top bit
    inject(5, 39'd1 << 20, 1);  drain("R3 drain data bit");
    reg_read(3'd2, d); check_eq("R6 scnt 1", 64'(d), 1);
    inject(15, 39'd1, 1);       drain("R1 drain parity bit");
    inject(0, 39'd1 << 1, 1);   drain("R1 drain check bit");
    inject(9, 39'd1 << 38, 1);  drain("R3 drain top bit");
    reg_read(3'd2, d); check_eq("R6 scnt 4", 64'(d), 4);

    // R5/R7: uncorrectable in frame 1, then frame 3
    dbl_round(6, (39'd1 << 3) | (39'd1 << 10), 1);
    reg_read(3'd3, d); check_eq("R5 dcnt 1", 64'(d), 1);
    reg_read(3'd2, d); check_eq("R5 scnt unchanged", 64'(d), 4);
    reg_read(3'd1, d); check_eq("R7 flag set", 64'(d), 1);
    reg_read(3'd4, d); check_eq("R7 frame 1", 64'(d), 1);
    dbl_round(13, (39'd1 << 0) | (39'd1 << 25), 2);
    reg_read(3'd3, d); check_eq("R7 dcnt 2", 64'(d), 2);
    reg_read(3'd4, d); check_eq("R7 frame held", 64'(d), 1);

    // R8: writes that must not clear
    reg_write(3'd0, 32'h0000_0002);
    reg_write(3'd2, 32'hFFFF_FFFF);
    reg_read(3'd2, d); check_eq("R8 no clear scnt", 64'(d), 4);
    reg_read(3'd1, d); check_eq("R8 no clear flag", 64'(d), 1);
    reg_write(3'd0, 32'h1);
    reg_read(3'd2, d); check_eq("R8 scnt cleared", 64'(d), 0);
    reg_read(3'd3, d); check_eq("R8 dcnt cleared", 64'(d), 0);
    reg_read(3'd1, d); check_eq("R8 flag cleared", 64'(d), 0);
    reg_read(3'd4, d); check_eq("R8 frame cleared", 64'(d), 0);

    // R7 recapture after clear; R5 three-bit fault with out-of-range syndrome
    dbl_round(13, (39'd1 << 4) | (39'd1 << 9), 1);
    reg_read(3'd4, d); check_eq("R7 frame recaptured", 64'(d), 3);
    dbl_round(2, (39'd1 << 32) | (39'd1 << 8) | (39'd1 << 7), 2);
    reg_read(3'd3, d); check_eq("R5 triple counted", 64'(d), 2);
    reg_read(3'd4, d); check_eq("R5 frame kept", 64'(d), 3);

    // R9: request while busy is ignored
    inject(4, 39'd1 << 7, 1);
    check_eq("R9 busy", 64'(inj_busy), 1);
    inj_req = 1; inj_addr = 4'd11; inj_mask = 39'd1 << 5;
    @(negedge clk); inj_req = 0;
    drain("R9 drain busy");

    // R6: saturation after nine more singles
    for (int k = 0; k < 9; k++) begin
      inject(k, 39'd1 << ((k * 4 + 2) % CW), 1);
      drain("R6 drain sat");
    end
    reg_read(3'd2, d); check_eq("R6 saturated", 64'(d), 7);

    repeat (3 * DEPTH + 10) @(negedge clk);
    check_eq("R3 no stray writes", 64'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule